// File: doc/BRIEF.md
# Selectable-Order Burst Address Sequencer

This block generates the addresses of a four-beat memory burst. The enclosing memory controller presents a full word address together with a load strobe. The sequencer captures that address and then drives it unchanged as beat 0. Each later cycle with the active-low advance input asserted moves to the next beat. Only the two least significant address bits take part in the burst. The bits above them keep the loaded value for the whole burst.

A static order input selects how the low two bits move. In interleaved order each beat is the start value XOR the beat index. In linear order each beat is the start value plus the beat index, modulo 4. When advance is not asserted the current beat is held, so the burst can be suspended mid-way and resumed later. The two-bit beat counter wraps after the fourth beat, and a further advance returns to the start address.

The memory array and the enable and write decoding are not part of this block. They live in the enclosing controller, which uses `addr_o` as the array address for each cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the stored address and the beat counter clear, so `addr_o` is 0 and `beat_o` is 0 after that edge.
- R2: A rising edge with `load_i` = 1 captures `addr_i`. After that edge `addr_o` equals `addr_i` and `beat_o` is 0.
- R3: During a burst, every bit of `addr_o` above bit 1 keeps the value it had at the last load.
- R4: With `mode_i` = 1 (interleaved), `addr_o[1:0]` equals the loaded bits [1:0] XOR `beat_o`. From a start of (a1,a0) the sequence is (a1,a0), (a1,~a0), (~a1,a0), (~a1,~a0).
- R5: With `mode_i` = 0 (linear), `addr_o[1:0]` equals the loaded bits [1:0] plus `beat_o`, modulo 4. For example, a start of 2 gives 2, 3, 0, 1.
- R6: A rising edge with `load_i` = 0 and `adv_n_i` = 1 changes neither `beat_o` nor `addr_o` (the burst is suspended).
- R7: A rising edge with `load_i` = 1 restarts at beat 0 from `addr_i`, even when `adv_n_i` = 0 in the same cycle.
- R8: A rising edge with `load_i` = 0 and `adv_n_i` = 0 increments `beat_o` by one, modulo 4. An advance from beat 3 returns `beat_o` to 0 and `addr_o` to the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture `addr_i` and restart the burst at beat 0 |
| adv_n_i | input | 1 | Advance to the next beat, active low; high holds the current beat |
| mode_i | input | 1 | Burst order: 1 selects interleaved, 0 selects linear; held static |
| addr_i | input | ADDR_W | Word address to load |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index, 0 to 3 |

## Verification
Every one of the four start values of the low bits is loaded in both orders and followed beat by beat through a full burst and the wrap. This sweep is what separates the XOR order from the add order: the two orders agree for some start and beat pairs but differ for others, such as start 1 at beat 1. The upper address bits carry an irregular pattern, so any leak of a carry or XOR above bit 1 shows up. Separate sequences pause the burst with advance high in the middle of a burst, and raise load together with advance to confirm that load wins.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic advance;
    } seq_cmd_t;

    function automatic beat_t burst_low(beat_t start, beat_t idx, order_e ord);
        beat_t res;
        if (ord == ORD_INTERLEAVED) begin
            res = start ^ idx;
        end else begin
            res = start + idx;
        end
        return res;
    endfunction

endpackage

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_o
);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= addr_in;
        end
    end

    assign base_o = base_q;

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load |=> base_q == $past(addr_in)); // R2

    AST_BASE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(base_q[ADDR_W-1:BEAT_W])); // R3

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_cmd_t cmd,
    output beat_t    beat_o
);

    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (cmd.load) begin
            beat_q <= '0;
        end else if (cmd.advance) begin
            beat_q <= beat_q + beat_t'(1);
        end
    end

    assign beat_o = beat_q;

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> beat_q == '0); // R7

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && !cmd.advance) |=> $stable(beat_q)); // R6

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && cmd.advance) |=> beat_q == beat_t'($past(beat_q) + beat_t'(1))); // R8

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] base_i,
    input  beat_t             beat_i,
    input  order_e            order_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    generate
        if (UPPER_W > 0) begin : g_upper
            assign addr_o[ADDR_W-1:BEAT_W] = base_i[ADDR_W-1:BEAT_W];
        end
    endgenerate

    assign addr_o[BEAT_W-1:0] = burst_low(base_i[BEAT_W-1:0], beat_i, order_i);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o
);

    seq_cmd_t          cmd;
    beat_t             beat;
    logic [ADDR_W-1:0] base;
    order_e            order;

    assign cmd.load    = load_i;
    assign cmd.advance = ~adv_n_i;
    assign order       = order_e'(mode_i);

    burst_addr_reg #(.ADDR_W(ADDR_W)) addr_reg_i (
        .clk     (clk),
        .rst     (rst),
        .load    (cmd.load),
        .addr_in (addr_i),
        .base_o  (base)
    );

    burst_beat_ctr beat_ctr_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .beat_o (beat)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) order_map_i (
        .base_i  (base),
        .beat_i  (beat),
        .order_i (order),
        .addr_o  (addr_o)
    );

    assign beat_o = beat;

    AST_BEAT0_IS_BASE: assert property (@(posedge clk) disable iff (rst)
        beat == '0 |-> addr_o == base); // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_n_i) |=> $stable(addr_o) || !$stable(mode_i)); // R6

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;

    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_i = 1'b0;
    logic              adv_n_i = 1'b1;
    logic              mode_i = 1'b1;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic [1:0]        beat_o;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .mode_i  (mode_i),
        .addr_i  (addr_i),
        .addr_o  (addr_o),
        .beat_o  (beat_o)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] got_a,
                         input logic [ADDR_W-1:0] exp_a, input logic [1:0] got_b,
                         input logic [1:0] exp_b);
        n_checks++;
        if (got_a !== exp_a || got_b !== exp_b) begin
            n_fail++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, got_a, got_b, exp_a, exp_b);
        end
    endtask

    // drive at falling edge, take the rising edge, sample mid-high phase
    task automatic step(input logic ld, input logic advn, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        load_i  = ld;
        adv_n_i = advn;
        addr_i  = a;
        @(posedge clk);
        #5;
    endtask

    function automatic logic [1:0] ref_low(input logic [1:0] s, input logic [1:0] k,
                                           input logic md);
        return md ? (s ^ k) : 2'(s + k);
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        step(1'b1, 1'b0, 19'h7FFFF);
        check("R1 reset", addr_o, '0, beat_o, 2'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_sweep(input logic md);
        logic [ADDR_W-1:0] base;
        @(negedge clk);
        mode_i = md;
        for (int s = 0; s < 4; s++) begin
            base = {17'h16A5B, 2'(s)};
            step(1'b1, 1'b1, base);
            check("R2 load", addr_o, base, beat_o, 2'd0);
            for (int k = 1; k <= 4; k++) begin
                step(1'b0, 1'b0, ~base);
                check(md ? "R4 interleaved/R3" : "R5 linear/R3", addr_o,
                      {base[ADDR_W-1:2], ref_low(2'(s), 2'(k), md)}, beat_o, 2'(k));
            end
            // k=4 above checks R8 wrap back to start
            check("R8 wrap", addr_o, base, beat_o, 2'd0);
        end
    endtask

    task automatic t_suspend();
        logic [ADDR_W-1:0] base;
        base = 19'h2C3D1;
        @(negedge clk);
        mode_i = 1'b0;
        step(1'b1, 1'b1, base);
        step(1'b0, 1'b0, '0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 19'h55555);
            check("R6 suspend", addr_o, {base[ADDR_W-1:2], 2'd2}, beat_o, 2'd1);
        end
        step(1'b0, 1'b0, '0);
        check("R6 resume", addr_o, {base[ADDR_W-1:2], 2'd3}, beat_o, 2'd2);
    endtask

    task automatic t_priority();
        logic [ADDR_W-1:0] base;
        base = 19'h4F0E2;
        @(negedge clk);
        mode_i = 1'b1;
        step(1'b1, 1'b1, 19'h11111);
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        step(1'b1, 1'b0, base);
        check("R7 load over advance", addr_o, base, beat_o, 2'd0);
        step(1'b0, 1'b0, '0);
        check("R7 after restart", addr_o, base ^ 19'd1, beat_o, 2'd1);
    endtask

    initial begin
        t_reset();
        t_sweep(1'b1);
        t_sweep(1'b0);
        t_suspend();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule